// File: doc/BRIEF.md
# Scintillator Bar Coincidence Trigger

This block builds a detector trigger from 32 discriminated SiPM hit lines. The lines arrive on two cables of sixteen channels each. Every line is brought into the clock domain and then stretched to a programmable coincidence window. A per-channel disable mask can then remove the line from all further logic.

Sixteen scintillator bars are read out at both ends. Eight bars sit on each cable, and their two ends land on channels through a fixed, non-sequential map. A bar fires only when both of its ends are active at the same time. A per-bar enable mask selects which bars feed the cable-level OR, giving signal A for the first cable and signal B for the second. A mode input combines A and B into the final trigger, either as an OR or as an AND.

The 32 gated hit lines and the A, B and final trigger signals all leave the block from registers, ready for a downstream timestamping stage.

Top module: `scint_trigger`

## Requirements
- R1: A one-cycle hit presented before clock edge k appears on the registered outputs after edge k+3. It is visible while sampling between edges k+3 and k+4 and is absent one cycle earlier.
- R2: On the first cable, bar j (0..7) is the AND of a left channel and a right channel. The left channels for j = 0..7 are 0, 1, 10, 11, 2, 3, 8, 9. The matching right channels are 14, 15, 6, 7, 12, 13, 4, 5. One end alone, or two ends that belong to different bars, never raises `trig_a_o`.
- R3: Each channel is stretched to `win_len_i` cycles, with a value of 0 treated as 1. A one-cycle hit shows on `hit_o` for exactly that many cycles. Two ends offset by d cycles coincide only when d is less than the window.
- R4: A 1 in bit i of `in_disable_i` forces channel i to 0 in both `hit_o` and all bar logic. The effect starts at the next clock edge.
- R5: Bit j of `bar_en_i` enables bar j of the first cable into `trig_a_o`. Bit 8+j enables bar j of the second cable into `trig_b_o`. A cleared bit removes only that bar.
- R6: With `and_mode_i` = 0, `trig_o` is `trig_a_o` OR `trig_b_o`. With `and_mode_i` = 1, it is their AND. The mode is taken at the same edge as the bar results.
- R7: `hit_o[i]` carries the stretched, disable-gated version of channel i, on the same edge as the trigger outputs.
- R8: While `rst_n` is low, every output is 0, including `trig_o`, even with all hits active. After release, no stale stretch survives.
- R9: The second cable uses the same bar layout as R2, with every channel number offset by 16, and it drives `trig_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | 32 | Raw discriminated SiPM hits; 0..15 first cable, 16..31 second cable |
| in_disable_i | input | 32 | Per-channel disable, 1 = suppressed |
| bar_en_i | input | 16 | Per-bar enable; 7..0 first cable, 15..8 second cable |
| and_mode_i | input | 1 | 0 = final trigger is A OR B, 1 = A AND B |
| win_len_i | input | 4 | Coincidence window in cycles (0 acts as 1) |
| hit_o | output | 32 | Registered, stretched, gated hit channels |
| trig_a_o | output | 1 | Registered first-cable bar OR |
| trig_b_o | output | 1 | Registered second-cable bar OR |
| trig_o | output | 1 | Registered combined trigger |

## Verification
A hit applied before edge k passes two synchronizer flops and the stretch counter before reaching the output register. Its results are therefore due after edge k+3. The latency test samples at the falling edge before and after that edge to confirm both the absence and the arrival. Pattern, mask and mode tests drive stimulus at falling edges and OR every output over a window longer than latency plus the largest stretch. This makes each expected value independent of the exact edge. Stretch-length checks count the falling edges on which a hit output stays high, and the reset check samples one nanosecond after `rst_n` falls.

// File: rtl/scint_trig_pkg.sv
package scint_trig_pkg;

  localparam int unsigned CH_PER_CABLE   = 16;
  localparam int unsigned NUM_CABLES     = 2;
  localparam int unsigned NUM_CH         = CH_PER_CABLE * NUM_CABLES;
  localparam int unsigned BARS_PER_CABLE = CH_PER_CABLE / 2;
  localparam int unsigned NUM_BARS       = BARS_PER_CABLE * NUM_CABLES;

  // Bars come in adjacent pairs; each pair takes a two-channel group
  // at each end, lower channel to the lower bar.
  function automatic int unsigned left_end(input int unsigned bar);
    int unsigned grp;
    case (bar / 2)
      0:       grp = 0;
      1:       grp = 10;
      2:       grp = 2;
      default: grp = 8;
    endcase
    return grp + (bar % 2);
  endfunction

  function automatic int unsigned right_end(input int unsigned bar);
    int unsigned grp;
    case (bar / 2)
      0:       grp = 14;
      1:       grp = 6;
      2:       grp = 12;
      default: grp = 4;
    endcase
    return grp + (bar % 2);
  endfunction

endpackage

// File: rtl/scint_rst_sync.sv
module scint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/scint_sync_bank.sv
module scint_sync_bank #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scint_stretch_bank.sv
module scint_stretch_bank #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] win_len_i,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] active_o
);
  logic [CNT_W-1:0] win_eff;

  always_comb begin
    win_eff = (win_len_i == '0) ? CNT_W'(1) : win_len_i;
  end

  for (genvar c = 0; c < WIDTH; c++) begin : g_ch
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_en;

    always_comb begin
      cnt_en = in_i[c] || (cnt_q != '0);
      cnt_d  = in_i[c] ? win_eff : (cnt_q - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign active_o[c] = (cnt_q != '0);

    AST_STRETCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      in_i[c] |=> active_o[c]);                                   // R3
    AST_STRETCH_ENDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o[c]) |-> !$past(in_i[c]));                    // R3
  end
endmodule

// File: rtl/scint_bar_combine.sv
module scint_bar_combine
  import scint_trig_pkg::*;
(
  input  logic [NUM_CH-1:0]   ends_i,
  input  logic [NUM_BARS-1:0] bar_en_i,
  input  logic                and_mode_i,
  output logic                cable_a_o,
  output logic                cable_b_o,
  output logic                trig_o
);
  logic [NUM_BARS-1:0] bar_hit;

  for (genvar cb = 0; cb < NUM_CABLES; cb++) begin : g_cable
    for (genvar b = 0; b < BARS_PER_CABLE; b++) begin : g_bar
      localparam int unsigned LCH = cb * CH_PER_CABLE + left_end(b);
      localparam int unsigned RCH = cb * CH_PER_CABLE + right_end(b);
      localparam int unsigned IDX = cb * BARS_PER_CABLE + b;
      assign bar_hit[IDX] = ends_i[LCH] & ends_i[RCH] & bar_en_i[IDX];
    end
  end

  always_comb begin
    cable_a_o = |bar_hit[BARS_PER_CABLE-1:0];
    cable_b_o = |bar_hit[NUM_BARS-1:BARS_PER_CABLE];
    trig_o    = and_mode_i ? (cable_a_o & cable_b_o) : (cable_a_o | cable_b_o);
  end
endmodule

// File: rtl/scint_trigger.sv
module scint_trigger
  import scint_trig_pkg::*;
#(
  parameter int unsigned WIN_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   hit_i,
  input  logic [NUM_CH-1:0]   in_disable_i,
  input  logic [NUM_BARS-1:0] bar_en_i,
  input  logic                and_mode_i,
  input  logic [WIN_W-1:0]    win_len_i,
  output logic [NUM_CH-1:0]   hit_o,
  output logic                trig_a_o,
  output logic                trig_b_o,
  output logic                trig_o
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] hit_sync;
  logic [NUM_CH-1:0] hit_str;
  logic [NUM_CH-1:0] hit_gated;
  logic              a_d, b_d, t_d;

  scint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  scint_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hit_i),
    .q_o   (hit_sync)
  );

  scint_stretch_bank #(.WIDTH(NUM_CH), .CNT_W(WIN_W)) u_stretch (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .win_len_i (win_len_i),
    .in_i      (hit_sync),
    .active_o  (hit_str)
  );

  always_comb begin
    hit_gated = hit_str & ~in_disable_i;
  end

  scint_bar_combine u_comb (
    .ends_i     (hit_gated),
    .bar_en_i   (bar_en_i),
    .and_mode_i (and_mode_i),
    .cable_a_o  (a_d),
    .cable_b_o  (b_d),
    .trig_o     (t_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o    <= '0;
      trig_a_o <= 1'b0;
      trig_b_o <= 1'b0;
      trig_o   <= 1'b0;
    end else if (!rst_n_s) begin
      hit_o    <= '0;
      trig_a_o <= 1'b0;
      trig_b_o <= 1'b0;
      trig_o   <= 1'b0;
    end else begin
      hit_o    <= hit_gated;
      trig_a_o <= a_d;
      trig_b_o <= b_d;
      trig_o   <= t_d;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !trig_o && !trig_a_o && !trig_b_o && (hit_o == '0));        // R8
  AST_AND_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (trig_o && $past(and_mode_i)) |-> (trig_a_o && trig_b_o));             // R6
  AST_TRIG_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_o |-> (trig_a_o || trig_b_o));                                    // R6
  AST_A_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_a_o |-> ($countones($past(hit_gated[CH_PER_CABLE-1:0])) >= 2));   // R2
  AST_B_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_b_o |-> ($countones($past(hit_gated[NUM_CH-1:CH_PER_CABLE])) >= 2)); // R9
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((hit_o & $past(in_disable_i)) == '0));                                // R4
endmodule

// File: tb/scint_trigger_tb.sv
module scint_trigger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] hit_i;
  logic [31:0] in_disable_i;
  logic [15:0] bar_en_i;
  logic        and_mode_i;
  logic [3:0]  win_len_i;
  logic [31:0] hit_o;
  logic        trig_a_o, trig_b_o, trig_o;

  int n_chk  = 0;
  int n_fail = 0;

  int lt [8] = '{0, 1, 10, 11, 2, 3, 8, 9};
  int rt [8] = '{14, 15, 6, 7, 12, 13, 4, 5};

  always #4 clk = ~clk;

  scint_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .in_disable_i(in_disable_i),
    .bar_en_i(bar_en_i), .and_mode_i(and_mode_i), .win_len_i(win_len_i),
    .hit_o(hit_o), .trig_a_o(trig_a_o), .trig_b_o(trig_b_o), .trig_o(trig_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bar_mask(input int cable, input int bar);
    return (32'h1 << (lt[bar] + 16*cable)) | (32'h1 << (rt[bar] + 16*cable));
  endfunction

  task automatic fire(input logic [31:0] m);
    @(negedge clk) hit_i = m;
    @(negedge clk) hit_i = '0;
  endtask

  task automatic watch(input int n, output logic sa, output logic sb, output logic st);
    sa = 0; sb = 0; st = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sa |= trig_a_o; sb |= trig_b_o; st |= trig_o;
    end
  endtask

  task automatic defaults();
    in_disable_i = '0; bar_en_i = 16'hFFFF; and_mode_i = 1'b0; win_len_i = 4'd1;
  endtask

  task automatic t_reset();
    logic sa, sb, st;
    rst_n = 1'b0; defaults(); hit_i = '1;
    repeat (6) @(negedge clk);
    chk("R8 reset outputs", {trig_o, trig_a_o, trig_b_o}, 32'h0);
    chk("R8 reset hits", hit_o, 32'h0);
    hit_i = '0;
    rst_n = 1'b1;
    watch(24, sa, sb, st);
    chk("R8 no stale stretch after release", {st, sa, sb}, 32'h0);
  endtask

  task automatic t_latency();
    defaults();
    fire(bar_mask(0, 0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 not yet at k+2", {trig_a_o, trig_o}, 32'h0);
    @(negedge clk);
    chk("R1 due at k+3", {trig_a_o, trig_o}, 32'h3);
    chk("R7 hit_o same edge", hit_o, bar_mask(0, 0));
    @(negedge clk);
    chk("R3 window 1 drops", {trig_a_o, trig_o}, 32'h0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_map();
    logic sa, sb, st;
    defaults();
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 8; b++) begin
        fire(bar_mask(c, b));
        watch(16, sa, sb, st);
        if (c == 0) chk($sformatf("R2 bar %0d pair", b), {sa, sb, st}, 32'h5);
        else        chk($sformatf("R9 bar %0d pair", b), {sa, sb, st}, 32'h3);
        fire(32'h1 << (lt[b] + 16*c));
        watch(16, sa, sb, st);
        chk($sformatf("R2 single end cable %0d bar %0d", c, b), {sa, sb, st}, 32'h0);
      end
    end
    fire((32'h1 << 0) | (32'h1 << 6));
    watch(16, sa, sb, st);
    chk("R2 ends of different bars", {sa, sb, st}, 32'h0);
    fire((32'h1 << 16) | (32'h1 << 31));
    watch(16, sa, sb, st);
    chk("R9 ends of different bars", {sa, sb, st}, 32'h0);
  endtask

  task automatic t_mode();
    logic sa, sb, st;
    defaults();
    and_mode_i = 1'b1;
    fire(bar_mask(0, 3));
    watch(16, sa, sb, st);
    chk("R6 AND with only A", {sa, sb, st}, 32'h4);
    fire(bar_mask(0, 3) | bar_mask(1, 6));
    watch(16, sa, sb, st);
    chk("R6 AND with A and B", {sa, sb, st}, 32'h7);
    and_mode_i = 1'b0;
    fire(bar_mask(1, 6));
    watch(16, sa, sb, st);
    chk("R6 OR with only B", {sa, sb, st}, 32'h3);
  endtask

  task automatic t_bar_en();
    logic sa, sb, st;
    defaults();
    bar_en_i = 16'hFFFF & ~16'h0010 & ~16'h0200;
    fire(bar_mask(0, 4) | bar_mask(1, 1));
    watch(16, sa, sb, st);
    chk("R5 disabled bars silent", {sa, sb, st}, 32'h0);
    fire(bar_mask(0, 5) | bar_mask(1, 2));
    watch(16, sa, sb, st);
    chk("R5 other bars still fire", {sa, sb, st}, 32'h7);
  endtask

  task automatic t_disable();
    logic sa, sb, st;
    logic [31:0] seen;
    defaults();
    in_disable_i = 32'h1 << 14;
    seen = '0;
    fire(bar_mask(0, 0));
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      seen |= hit_o;
      sa = trig_a_o;
      if (sa) chk("R4 bar with disabled end", 32'h1, 32'h0);
    end
    chk("R4 R7 hit_o gated", seen, 32'h1);
    in_disable_i = '0;
    fire(bar_mask(0, 0));
    watch(16, sa, sb, st);
    chk("R4 re-enabled end fires", {sa, sb, st}, 32'h5);
  endtask

  task automatic t_window();
    logic sa, sb, st;
    int cnt;
    defaults();
    win_len_i = 4'd3;
    fire(32'h1 << 0);
    @(negedge clk); hit_i = 32'h1 << 14;
    @(negedge clk); hit_i = '0;
    watch(20, sa, sb, st);
    chk("R3 offset 2 inside window 3", {sa, st}, 32'h3);
    win_len_i = 4'd2;
    fire(32'h1 << 0);
    @(negedge clk); hit_i = 32'h1 << 14;
    @(negedge clk); hit_i = '0;
    watch(20, sa, sb, st);
    chk("R3 offset 2 outside window 2", {sa, st}, 32'h0);
    for (int w = 0; w < 16; w += 5) begin
      win_len_i = 4'(w);
      fire(32'h1 << 20);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (hit_o[20]) cnt++;
      end
      chk($sformatf("R3 R7 stretch length w=%0d", w), cnt, (w == 0) ? 1 : w);
    end
  endtask

  task automatic t_reset_mid();
    defaults();
    @(negedge clk) hit_i = bar_mask(0, 2);
    repeat (6) @(negedge clk);
    chk("R8 held pair active", {trig_a_o, trig_o}, 32'h3);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", {trig_o, trig_a_o, trig_b_o}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 stays low in reset", {trig_o, trig_a_o}, 32'h0);
    hit_i = '0;
    rst_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_map();
    t_mode();
    t_bar_en();
    t_disable();
    t_window();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule